// File: doc/BRIEF.md
# Sticky Error Status Register with Clear-on-Read and Interrupt

This block gathers error events reported by a command engine into one 64-bit status word that the host can read. Each event arrives as a one-cycle pulse. It carries a vector of error-type bits, a soft/hard class and the index of the command that failed.

Error-type bits and class flags are sticky and accumulate across events. The command index field is overwritten, so it always names the most recent failure. Every accepted event also produces a one-cycle done pulse for the failed command.

While any error is held, the interrupt output sits at its active level. A configuration input selects whether that level is high or low.

A host read captures the whole word into the read-data output one cycle later. The same clock edge clears the register in a single step. An event that arrives on the read edge is not lost: it is not in the returned word, and it becomes the new content after the clear.

The control is a two-state machine:
- `ST_CLEAN`: nothing is held.
- `ST_FLAGGED`: at least one error is held.

It has four named transitions:
- `ERR_IN`: an error arrives in `ST_CLEAN`, and the machine moves to `ST_FLAGGED`.
- `READ_EMPTY`: a read with no error in `ST_FLAGGED` returns the machine to `ST_CLEAN`.
- `READ_REFILL`: a read that coincides with an error keeps the machine in `ST_FLAGGED`.
- `HOLD`: in every other case the state is kept.

Top module: `err_status_reg`

## Requirements
- R1: After reset the status word is all zero, `rd_valid` and `done` are low, and `intr` is at its inactive level.
- R2: Error-type bits [15:0] are the bitwise OR of the `err_bits` of every event accepted since the last clear.
- R3: Bit 16 (soft) is set by any event with `err_hard`=0, and bit 17 (hard) is set by any event with `err_hard`=1. Both flags stay set until cleared.
- R4: Bits [24:18] hold the `err_index` of the most recent accepted event.
- R5: `done` is high for exactly the cycle after each cycle in which `err_valid` is high.
- R6: A read (`rd_req` high at an edge) makes `rd_valid` high for one cycle after that edge. `rd_data` then equals the status word as it stood before that edge.
- R7: A read with no coinciding error leaves the status word all zero.
- R8: An error on the same edge as a read is absent from that read's data. After the clear it is the only content of the word.
- R9: `intr` equals `intr_active_high` while the status word is nonzero and equals its inverse while the word is zero.
- R10: Bits [63:25] always read as zero.
- R11: In a cycle with neither an error nor a read, the status word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_valid | input | 1 | Error event strobe, one cycle per event |
| err_bits | input | 16 | Error-type bits of the event |
| err_hard | input | 1 | Event class: 1 hard, 0 soft |
| err_index | input | 7 | Index of the failing command |
| intr_active_high | input | 1 | Interrupt polarity: 1 active high, 0 active low |
| rd_req | input | 1 | Host read request; clears the word on the same edge |
| rd_data | output | 64 | Snapshot of the status word, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_req |
| done | output | 1 | Done flag for the command of the last accepted error |
| intr | output | 1 | Interrupt, level set by intr_active_high |

## Verification
Two events with different bit patterns, classes and indices are stacked before a read. The readback separates OR-accumulation from overwriting, and it separates a sticky index from a last-writer index. A read that collides with a third event checks that the word returned excludes that event while the next word contains it alone. An immediate second read after a clean read shows the clear. Idle stretches between events expose any drift. Both settings of the polarity input are tried with the word empty and with it full, which tells an inverted interrupt apart from a missing one.

// File: rtl/esr_pkg.sv
package esr_pkg;

    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_FLAGGED = 1'b1
    } esr_state_e;

endpackage

// File: rtl/esr_fsm.sv
module esr_fsm
    import esr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_valid,
    input  logic rd_req,
    output logic pending
);

    esr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: begin
                if (err_valid) state_d = ST_FLAGGED;          // ERR_IN
            end
            ST_FLAGGED: begin
                if (rd_req && !err_valid) state_d = ST_CLEAN; // READ_EMPTY
                else                      state_d = ST_FLAGGED; // READ_REFILL / HOLD
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    always_comb pending = (state_q == ST_FLAGGED);

endmodule

// File: rtl/esr_accum.sv
module esr_accum #(
    parameter int ERR_W = 16,
    parameter int IDX_W = 7,
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_valid,
    input  logic [ERR_W-1:0] err_bits,
    input  logic             err_hard,
    input  logic [IDX_W-1:0] err_index,
    input  logic             rd_req,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             done
);

    localparam int SOFT_POS = ERR_W;
    localparam int HARD_POS = ERR_W + 1;
    localparam int IDX_LSB  = ERR_W + 2;

    logic [REG_W-1:0] base, status_d;

    always_comb begin
        base     = rd_req ? '0 : status_q;
        status_d = base;
        if (err_valid) begin
            status_d[ERR_W-1:0]         = base[ERR_W-1:0] | err_bits;
            status_d[SOFT_POS]          = base[SOFT_POS] | ~err_hard;
            status_d[HARD_POS]          = base[HARD_POS] | err_hard;
            status_d[IDX_LSB +: IDX_W]  = err_index;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
        end else begin
            status_q <= status_d;
            rd_valid <= rd_req;
            done     <= err_valid;
            if (rd_req) rd_data <= status_q;
        end
    end

endmodule

// File: rtl/esr_intr.sv
module esr_intr (
    input  logic pending,
    input  logic intr_active_high,
    output logic intr
);

    always_comb intr = intr_active_high ? pending : ~pending;

endmodule

// File: rtl/err_status_reg.sv
module err_status_reg #(
    parameter int ERR_W = 16,
    parameter int IDX_W = 7,
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_valid,
    input  logic [ERR_W-1:0] err_bits,
    input  logic             err_hard,
    input  logic [IDX_W-1:0] err_index,
    input  logic             intr_active_high,
    input  logic             rd_req,
    output logic [REG_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             intr
);

    logic [REG_W-1:0] status_q;
    logic             pending;

    esr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_valid (err_valid),
        .rd_req    (rd_req),
        .pending   (pending)
    );

    esr_accum #(.ERR_W(ERR_W), .IDX_W(IDX_W), .REG_W(REG_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_valid (err_valid),
        .err_bits  (err_bits),
        .err_hard  (err_hard),
        .err_index (err_index),
        .rd_req    (rd_req),
        .status_q  (status_q),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .done      (done)
    );

    esr_intr u_intr (
        .pending          (pending),
        .intr_active_high (intr_active_high),
        .intr             (intr)
    );

endmodule

// File: rtl/esr_checker.sv
module esr_checker #(
    parameter int ERR_W = 16,
    parameter int IDX_W = 7,
    parameter int REG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_valid,
    input logic [ERR_W-1:0] err_bits,
    input logic [IDX_W-1:0] err_index,
    input logic             rd_req,
    input logic [REG_W-1:0] status_q,
    input logic [REG_W-1:0] rd_data,
    input logic             rd_valid,
    input logic             done,
    input logic             intr,
    input logic             intr_active_high
);

    localparam int IDX_LSB = ERR_W + 2;
    localparam int USED_W  = IDX_LSB + IDX_W;

    AST_BITS_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !rd_req) |=> ((status_q[ERR_W-1:0] & $past(err_bits)) == $past(err_bits))); // R2

    AST_LAST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> (status_q[IDX_LSB +: IDX_W] == $past(err_index))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> done); // R5

    AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_valid && rd_data == $past(status_q))); // R6

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !err_valid) |=> (status_q == '0)); // R7

    AST_INTR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0) |-> (intr == intr_active_high)); // R9

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[REG_W-1:USED_W] == '0); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_valid && !rd_req) |=> $stable(status_q)); // R11

endmodule

bind err_status_reg esr_checker #(.ERR_W(ERR_W), .IDX_W(IDX_W), .REG_W(REG_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .err_valid        (err_valid),
    .err_bits         (err_bits),
    .err_index        (err_index),
    .rd_req           (rd_req),
    .status_q         (status_q),
    .rd_data          (rd_data),
    .rd_valid         (rd_valid),
    .done             (done),
    .intr             (intr),
    .intr_active_high (intr_active_high)
);

// File: tb/err_status_reg_test.sv
module err_status_reg_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_valid = 1'b0;
    logic [15:0] err_bits = '0;
    logic        err_hard = 1'b0;
    logic [6:0]  err_index = '0;
    logic        intr_active_high = 1'b1;
    logic        rd_req = 1'b0;
    logic [63:0] rd_data;
    logic        rd_valid;
    logic        done;
    logic        intr;

    int checks = 0;
    int errors = 0;

    logic [63:0] exp_reg = '0;
    logic        exp_done = 1'b0;
    logic [63:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    err_status_reg uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .err_valid        (err_valid),
        .err_bits         (err_bits),
        .err_hard         (err_hard),
        .err_index        (err_index),
        .intr_active_high (intr_active_high),
        .rd_req           (rd_req),
        .rd_data          (rd_data),
        .rd_valid         (rd_valid),
        .done             (done),
        .intr             (intr)
    );

    // Monitor: pop expected snapshots when read data appears (R6 R2 R3 R4 R7 R8 R10 R11)
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6 unexpected rd_valid: actual=%h expected=none", rd_data);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL R2 R3 R4 R7 R8 R10 R11 readback: actual=%h expected=%h", rd_data, e);
                end
            end
        end
    end

    task automatic check_outs();
        logic exp_intr;
        exp_intr = (exp_reg != 0) ? intr_active_high : ~intr_active_high;
        checks++;
        if (intr !== exp_intr) begin
            errors++;
            $display("FAIL R9 intr: actual=%b expected=%b", intr, exp_intr);
        end
        checks++;
        if (done !== exp_done) begin
            errors++;
            $display("FAIL R5 done: actual=%b expected=%b", done, exp_done);
        end
    endtask

    // Driver: one cycle of stimulus, pushes the expected read snapshot
    task automatic step(input logic v, input logic [15:0] b, input logic h,
                        input logic [6:0] ix, input logic rd);
        logic [63:0] nxt;
        @(negedge clk);
        check_outs();
        err_valid = v; err_bits = b; err_hard = h; err_index = ix; rd_req = rd;
        if (rd) exp_q.push_back(exp_reg);
        nxt = rd ? 64'd0 : exp_reg;
        if (v) begin
            nxt[15:0]  = nxt[15:0] | b;
            nxt[16]    = nxt[16] | ~h;
            nxt[17]    = nxt[17] | h;
            nxt[24:18] = ix;
        end
        @(posedge clk);
        exp_reg  = nxt;
        exp_done = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b0, 7'h0, 1'b0);
    endtask

    task automatic rd();
        step(1'b0, 16'h0, 1'b0, 7'h0, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        checks++;
        if (rd_valid !== 1'b0 || done !== 1'b0 || intr !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual=%b%b%b expected=000", rd_valid, done, intr);
        end
        rst_n = 1'b1;
        idle(2);
        rd();                                   // R1 word reads zero
        idle(1);
        step(1'b1, 16'h0005, 1'b0, 7'd3, 1'b0); // soft event
        idle(2);                                // R11 drift
        step(1'b1, 16'h0100, 1'b1, 7'd9, 1'b0); // hard event, new index (R2 R3 R4)
        step(1'b1, 16'h0004, 1'b0, 7'd40, 1'b0); // back-to-back, overlapping bit
        idle(1);
        step(1'b1, 16'h0002, 1'b0, 7'h7F, 1'b1); // R8 read collides with event
        idle(1);
        rd();                                   // sees only the collided event
        rd();                                   // R7 empty after clean read
        idle(1);
        intr_active_high = 1'b0;                // R9 active-low, idle -> intr high
        idle(2);
        step(1'b1, 16'h8000, 1'b1, 7'd64, 1'b0);
        idle(2);
        step(1'b1, 16'hFFFF, 1'b0, 7'd1, 1'b0);
        intr_active_high = 1'b1;
        idle(1);
        rd();
        idle(2);
        step(1'b1, 16'h0000, 1'b1, 7'd5, 1'b1); // read of empty word with event
        rd();
        idle(2);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 missing rd_valid: actual=%0d pending expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule